// File: doc/BRIEF.md
# Per-Slice Turn-by-Turn FIR Filter Bank

This block forms the digital core of a single-bunch feedback loop. Once per revolution the bunch is digitized as a fixed number of slices, and each slice arrives as a signed sample with its slice index. The first sample of each revolution also carries a turn marker. Every slice position has its own FIR filter. That filter runs across revolutions and sees only the earlier samples of its own slice. The filtered correction leaves the block in the same slice order, one cycle later, and goes to the kicker DAC.

Two full coefficient banks are stored. One bank drives the filters while the other is reloaded through a simple write port. A bank-select request changes the live bank at a turn boundary, so the filter histories are never disturbed. Each bank holds a coefficient for every slice and tap, plus one tap-count setting. Taps at or beyond that count contribute nothing. Every slice must be presented exactly once per revolution. The history depth must be a power of two.

Top module: `fir_slice_bank`

## Requirements
- R1: While reset is asserted and just after it, outValid, outSlice, outData and cfgErr are 0. The live bank is bank 0. All coefficients are 0, both tap counts are 1 and all histories are 0, so every output is 0 until a bank is loaded and selected.
- R2: For a sample x0 of slice s, with xk being the sample of slice s taken k turns earlier, outData = sat16(floor((sum over k < N of c[b][s][k]*xk + 2^15) / 2^16)). Here b is the live bank and N is its tap count.
- R3: A filter uses only the samples of its own slice index. A nonzero input on one slice leaves the outputs of all other slices unchanged on every later turn.
- R4: A tap-count write (cfgIsLen=1) stores cfgData read as unsigned. The value 0 is stored as 1, and values above 16 are stored as 16. Taps whose index is at or above the stored count act as zero.
- R5: The live bank becomes nextSet only when a sample arrives with inTurn=1. A change of nextSet in the middle of a turn has no effect until the next turn marker.
- R6: A coefficient or tap-count write whose cfgSet equals the live bank is discarded, and cfgErr goes to 1. cfgErr stays at 1 until reset. Writes to the other bank are applied and leave cfgErr as it is.
- R7: The rounded result is clamped to the range -32768 to 32767.
- R8: Each input sample yields exactly one output one clock later, with outValid=1 and outSlice equal to its inSlice. outValid is 0 in every other cycle.
- R9: Switching the live bank does not clear or shift the histories. The first turn on the new bank filters the history built under the old bank.
- R10: A reset applied mid-run clears all histories, coefficients, tap counts, the live bank and cfgErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A slice sample is present |
| inTurn | input | 1 | The sample is the first of a new turn |
| inSlice | input | 4 | Slice index of the sample |
| inSample | input | 16 | Signed ADC sample |
| nextSet | input | 1 | Requested bank for the next turn |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSet | input | 1 | Bank addressed by the write |
| cfgIsLen | input | 1 | 1: tap-count write, 0: coefficient write |
| cfgSlice | input | 4 | Slice addressed by a coefficient write |
| cfgTap | input | 4 | Tap addressed by a coefficient write |
| cfgData | input | 18 | Signed coefficient (16 fraction bits) or tap count |
| outValid | output | 1 | Correction sample present |
| outSlice | output | 4 | Slice index of the correction |
| outData | output | 16 | Signed correction for the DAC |
| cfgErr | output | 1 | Sticky flag for a write aimed at the live bank |

## Verification
A table of full turns drives linear patterns through the bank: flat, rising, falling, sign-alternating and full-scale. The patterns toggle the live bank between a 16-tap bank with a dominant first tap and a 3-tap bank. Ramps across slices expose any slice mix-up or wrong history ordering. Full-scale turns drive the sum past both 16-bit limits, so they separate clamping from wrap-around. Directed turns add a lone impulse on one slice, a mid-turn select change, a rejected write, tap counts of 0 and 20, and a mid-run reset. Each of these pins down one control rule of the block.

// File: rtl/fir_slice_bank_pkg.sv
`timescale 1ns/1ps
package fir_slice_bank_pkg;

  // Strobes the control unit hands to the datapath each cycle
  typedef struct packed {
    logic sampleGo;  // a slice sample is accepted this cycle
    logic turnSet;   // coefficient bank in force for this cycle's sample
    logic coefGo;    // coefficient write accepted
    logic lenGo;     // tap-count write accepted
    logic cfgSet;    // bank targeted by the accepted write
  } fbStrobe_t;

endpackage

// File: rtl/fir_slice_bank_ctrl.sv
`timescale 1ns/1ps
module fir_slice_bank_ctrl
  import fir_slice_bank_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inTurn,
  input  logic             nextSet,
  input  logic             cfgWe,
  input  logic             cfgSet,
  input  logic             cfgIsLen,
  output logic [PTR_W-1:0] turnPtr,
  output fbStrobe_t        strobe,
  output logic             cfgErr
);

  logic             activeSet;
  logic [PTR_W-1:0] ptrQ;
  logic             turnEdge;
  logic             effSet;
  logic [PTR_W-1:0] effPtr;
  logic             wrOk;
  logic             wrBad;

  assign turnEdge = inValid & inTurn;
  assign effSet   = turnEdge ? nextSet : activeSet;
  assign effPtr   = turnEdge ? ptrQ + 1'b1 : ptrQ;
  assign wrOk     = cfgWe & (cfgSet != effSet);
  assign wrBad    = cfgWe & (cfgSet == effSet);

  always_comb begin
    strobe.sampleGo = inValid;
    strobe.turnSet  = effSet;
    strobe.coefGo   = wrOk & ~cfgIsLen;
    strobe.lenGo    = wrOk & cfgIsLen;
    strobe.cfgSet   = cfgSet;
  end

  assign turnPtr = effPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSet <= 1'b0;
      ptrQ      <= '0;
      cfgErr    <= 1'b0;
    end else begin
      activeSet <= effSet;
      ptrQ      <= effPtr;
      if (wrBad) cfgErr <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);  // R6

  AST_BAD_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSet == strobe.turnSet) |=> cfgErr);  // R6

  AST_SET_HOLDS_MIDTURN: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inTurn) |=> $stable(activeSet));  // R5

  AST_PTR_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inTurn) |=> (ptrQ == $past(ptrQ) + 1'b1));  // R9

endmodule

// File: rtl/fir_slice_bank_dp.sv
`timescale 1ns/1ps
module fir_slice_bank_dp
  import fir_slice_bank_pkg::*;
#(
  parameter int NUM_SLICES = 16,
  parameter int MAX_TAPS   = 16,
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 18,
  parameter int FRAC_W     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(NUM_SLICES)-1:0] inSlice,
  input  logic signed [SAMPLE_W-1:0] inSample,
  input  logic [$clog2(MAX_TAPS)-1:0] turnPtr,
  input  fbStrobe_t                  strobe,
  input  logic [$clog2(NUM_SLICES)-1:0] cfgSlice,
  input  logic [$clog2(MAX_TAPS)-1:0] cfgTap,
  input  logic [COEF_W-1:0]          cfgData,
  output logic                       outValid,
  output logic [$clog2(NUM_SLICES)-1:0] outSlice,
  output logic signed [SAMPLE_W-1:0] outData
);

  localparam int SLICE_W = $clog2(NUM_SLICES);
  localparam int PTR_W   = $clog2(MAX_TAPS);
  localparam int LEN_W   = $clog2(MAX_TAPS + 1);
  localparam int PROD_W  = SAMPLE_W + COEF_W;
  localparam int ACC_W   = PROD_W + $clog2(MAX_TAPS);
  localparam logic signed [ACC_W-1:0] RND_HALF =
    {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] OUT_MAX =
    {{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN =
    {{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] histMem [NUM_SLICES][MAX_TAPS];
  logic signed [COEF_W-1:0]   coefMem [2][NUM_SLICES][MAX_TAPS];
  logic [LEN_W-1:0]           tapLen  [2];

  function automatic logic [LEN_W-1:0] clampLen(logic [COEF_W-1:0] v);
    if (v == '0)                   return LEN_W'(1);
    else if (v > COEF_W'(MAX_TAPS)) return LEN_W'(MAX_TAPS);
    else                           return v[LEN_W-1:0];
  endfunction

  // History: the current sample lands in the slot of this turn
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLICES; s++)
        for (int k = 0; k < MAX_TAPS; k++)
          histMem[s][k] <= '0;
    end else if (strobe.sampleGo) begin
      histMem[inSlice][turnPtr] <= inSample;
    end
  end

  // Coefficient banks; the control unit only lets writes through to the idle bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        tapLen[b] <= LEN_W'(1);
        for (int s = 0; s < NUM_SLICES; s++)
          for (int k = 0; k < MAX_TAPS; k++)
            coefMem[b][s][k] <= '0;
      end
    end else begin
      if (strobe.coefGo) coefMem[strobe.cfgSet][cfgSlice][cfgTap] <= cfgData;
      if (strobe.lenGo)  tapLen[strobe.cfgSet] <= clampLen(cfgData);
    end
  end

  // One product per tap; tap k reads the sample from k turns back
  logic signed [PROD_W-1:0] prodK [MAX_TAPS];

  for (genvar k = 0; k < MAX_TAPS; k++) begin : g_tap
    logic signed [SAMPLE_W-1:0] tapX;
    logic signed [COEF_W-1:0]   tapC;
    if (k == 0) begin : g_now
      assign tapX = inSample;
    end else begin : g_old
      assign tapX = histMem[inSlice][turnPtr - PTR_W'(k)];
    end
    assign tapC     = coefMem[strobe.turnSet][inSlice][k];
    assign prodK[k] = (LEN_W'(k) < tapLen[strobe.turnSet])
                      ? PROD_W'(tapC) * PROD_W'(tapX) : '0;
  end

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sumR;
  logic signed [ACC_W-1:0] scaled;
  logic signed [SAMPLE_W-1:0] satVal;

  always_comb begin
    acc = '0;
    for (int k = 0; k < MAX_TAPS; k++) acc = acc + ACC_W'(prodK[k]);
    sumR   = acc + RND_HALF;
    scaled = sumR >>> FRAC_W;
    if (scaled > OUT_MAX)      satVal = {1'b0, {(SAMPLE_W-1){1'b1}}};
    else if (scaled < OUT_MIN) satVal = {1'b1, {(SAMPLE_W-1){1'b0}}};
    else                       satVal = scaled[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSlice <= '0;
      outData  <= '0;
    end else begin
      outValid <= strobe.sampleGo;
      if (strobe.sampleGo) begin
        outSlice <= inSlice;
        outData  <= satVal;
      end
    end
  end

  AST_NO_LIVE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.coefGo || strobe.lenGo) |-> (strobe.cfgSet != strobe.turnSet));  // R6

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleGo |=> (outValid && outSlice == $past(inSlice)));  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleGo |=> !outValid);  // R8

  logic [SLICE_W-1:0] unusedSliceW;
  assign unusedSliceW = '0;

endmodule

// File: rtl/fir_slice_bank.sv
`timescale 1ns/1ps
module fir_slice_bank
  import fir_slice_bank_pkg::*;
#(
  parameter int NUM_SLICES = 16,
  parameter int MAX_TAPS   = 16,
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 18,
  parameter int FRAC_W     = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic                          inTurn,
  input  logic [$clog2(NUM_SLICES)-1:0] inSlice,
  input  logic signed [SAMPLE_W-1:0]    inSample,
  input  logic                          nextSet,
  input  logic                          cfgWe,
  input  logic                          cfgSet,
  input  logic                          cfgIsLen,
  input  logic [$clog2(NUM_SLICES)-1:0] cfgSlice,
  input  logic [$clog2(MAX_TAPS)-1:0]   cfgTap,
  input  logic [COEF_W-1:0]             cfgData,
  output logic                          outValid,
  output logic [$clog2(NUM_SLICES)-1:0] outSlice,
  output logic signed [SAMPLE_W-1:0]    outData,
  output logic                          cfgErr
);

  localparam int PTR_W = $clog2(MAX_TAPS);

  fbStrobe_t        strobe;
  logic [PTR_W-1:0] turnPtr;

  fir_slice_bank_ctrl #(.PTR_W(PTR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inTurn   (inTurn),
    .nextSet  (nextSet),
    .cfgWe    (cfgWe),
    .cfgSet   (cfgSet),
    .cfgIsLen (cfgIsLen),
    .turnPtr  (turnPtr),
    .strobe   (strobe),
    .cfgErr   (cfgErr)
  );

  fir_slice_bank_dp #(
    .NUM_SLICES (NUM_SLICES),
    .MAX_TAPS   (MAX_TAPS),
    .SAMPLE_W   (SAMPLE_W),
    .COEF_W     (COEF_W),
    .FRAC_W     (FRAC_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inSlice  (inSlice),
    .inSample (inSample),
    .turnPtr  (turnPtr),
    .strobe   (strobe),
    .cfgSlice (cfgSlice),
    .cfgTap   (cfgTap),
    .cfgData  (cfgData),
    .outValid (outValid),
    .outSlice (outSlice),
    .outData  (outData)
  );

endmodule

// File: tb/test_fir_slice_bank.sv
`timescale 1ns/1ps
module test_fir_slice_bank;

  localparam int NS = 16;
  localparam int MT = 16;

  typedef struct packed {
    logic              sel;
    logic signed [15:0] base;
    logic signed [15:0] step;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1,  16'sd100,    16'sd3},
    '{1'b1, -16'sd2000,   16'sd250},
    '{1'b0,  16'sd500,   -16'sd40},
    '{1'b0,  16'sd0,      16'sd0},
    '{1'b1,  16'sd32767,  16'sd0},
    '{1'b1, -16'sd32768,  16'sd0},
    '{1'b0,  16'sd1234,  -16'sd321},
    '{1'b1, -16'sd1,      16'sd1},
    '{1'b1,  16'sd20000, -16'sd2500},
    '{1'b0, -16'sd7,      16'sd7},
    '{1'b0,  16'sd300,    16'sd0},
    '{1'b1, -16'sd15000,  16'sd1999}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, inValid, inTurn, nextSet, cfgWe, cfgSet, cfgIsLen;
  logic [3:0] inSlice, cfgSlice, cfgTap;
  logic signed [15:0] inSample;
  logic [17:0] cfgData;
  logic outValid, cfgErr;
  logic [3:0] outSlice;
  logic signed [15:0] outData;

  fir_slice_bank i_fir_slice_bank (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTurn(inTurn),
    .inSlice(inSlice), .inSample(inSample), .nextSet(nextSet),
    .cfgWe(cfgWe), .cfgSet(cfgSet), .cfgIsLen(cfgIsLen),
    .cfgSlice(cfgSlice), .cfgTap(cfgTap), .cfgData(cfgData),
    .outValid(outValid), .outSlice(outSlice), .outData(outData),
    .cfgErr(cfgErr)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Bench model
  int bCoef [2][NS][MT];
  int bLen  [2];
  int bPast [NS][MT];
  int bSet, bReqSel;
  bit bErr;

  function automatic int satRound(longint acc);
    longint r;
    r = (acc + 64'sd32768) >>> 16;
    if (r > 32767)  return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic int coefA(int s, int k);
    if (k == 0) return 120000 - s * 500;
    return (((s * 7 + k * 13) % 37) - 18) * 1500;
  endfunction

  function automatic int coefB(int s, int k);
    case (k)
      0:       return 65536 - s * 1000;
      1:       return -32768;
      2:       return 16384 + s * 10;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int b = 0; b < 2; b++) begin
      bLen[b] = 1;
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < MT; k++) bCoef[b][s][k] = 0;
    end
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < MT; k++) bPast[s][k] = 0;
    bSet = 0; bReqSel = 0; bErr = 0;
  endtask

  task automatic cfgCoef(input int set, input int sl, input int tap, input int val);
    cfgWe = 1'b1; cfgSet = set[0]; cfgIsLen = 1'b0;
    cfgSlice = sl[3:0]; cfgTap = tap[3:0]; cfgData = val[17:0];
    @(negedge clk);
    cfgWe = 1'b0;
    if (set == bSet) bErr = 1;
    else bCoef[set][sl][tap] = val;
  endtask

  task automatic cfgLen(input int set, input int n);
    cfgWe = 1'b1; cfgSet = set[0]; cfgIsLen = 1'b1; cfgData = n[17:0];
    @(negedge clk);
    cfgWe = 1'b0; cfgIsLen = 1'b0;
    if (set == bSet) bErr = 1;
    else bLen[set] = (n == 0) ? 1 : (n > MT ? MT : n);
  endtask

  task automatic loadBank(input int set, input bit useA);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < MT; k++)
        cfgCoef(set, s, k, useA ? coefA(s, k) : coefB(s, k));
    cfgLen(set, useA ? 16 : 3);
  endtask

  // Drive one sample at the current falling edge, check its result one cycle later
  task automatic sample(input bit first, input int sl, input int val, input string req);
    logic signed [15:0] sv;
    longint acc;
    int x, expV;
    sv = val[15:0];
    x  = int'(sv);
    if (first) bSet = bReqSel;
    acc = 0;
    for (int k = 0; k < bLen[bSet]; k++)
      acc += longint'(bCoef[bSet][sl][k]) * longint'((k == 0) ? x : bPast[sl][k]);
    expV = satRound(acc);
    inValid = 1'b1; inTurn = first; inSlice = sl[3:0]; inSample = sv;
    @(negedge clk);
    chk(outValid === 1'b1 && outSlice == sl[3:0] && outData == expV[15:0],
        req, longint'(outData), longint'(expV));
    for (int k = MT - 1; k >= 2; k--) bPast[sl][k] = bPast[sl][k-1];
    bPast[sl][1] = x;
  endtask

  task automatic idleCheck();
    inValid = 1'b0; inTurn = 1'b0;
    @(negedge clk);
    chk(outValid === 1'b0, "R8", longint'(outValid), 0);
  endtask

  task automatic rampTurn(input int base, input int step, input string req);
    for (int s = 0; s < NS; s++) sample(s == 0, s, base + step * s, req);
    idleCheck();
  endtask

  task automatic impulseTurn(input int sl, input int val, input string req);
    for (int s = 0; s < NS; s++) sample(s == 0, s, (s == sl) ? val : 0, req);
    idleCheck();
  endtask

  task automatic selectNext(input int set);
    nextSet = set[0];
    bReqSel = set;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inTurn = 1'b0; inSlice = '0; inSample = '0;
    nextSet = 1'b0; cfgWe = 1'b0; cfgSet = 1'b0; cfgIsLen = 1'b0;
    cfgSlice = '0; cfgTap = '0; cfgData = '0;
    modelReset();
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0 && outData == 0 && outSlice == 0 && cfgErr === 1'b0,
        "R1", longint'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: zero coefficients after reset give zero outputs
    rampTurn(777, 111, "R1");

    // Load bank 1 while bank 0 is live, switch, then load bank 0
    loadBank(1, 1'b1);
    selectNext(1);
    rampTurn(50, -9, "R2");
    loadBank(0, 1'b0);
    chk(cfgErr === 1'b0, "R6", longint'(cfgErr), 0);

    // Table walk: R2 on steady banks, R9 on every bank change
    for (int i = 0; i < 12; i++) begin
      string req;
      req = (int'(VEC[i].sel) != bSet) ? "R9" : "R2";
      selectNext(int'(VEC[i].sel));
      rampTurn(int'(VEC[i].base), int'(VEC[i].step), req);
    end

    // R7: full-scale turns drive the sum beyond both limits
    selectNext(1);
    rampTurn(32767, 0, "R7");
    rampTurn(32767, 0, "R7");
    rampTurn(-32768, 0, "R7");
    rampTurn(-32768, 0, "R7");

    // R5: select changes mid-turn, live bank changes only at the next marker
    for (int s = 0; s < NS; s++) begin
      if (s == 8) selectNext(0);
      sample(s == 0, s, 900 - 60 * s, "R5");
    end
    idleCheck();
    rampTurn(-400, 55, "R5");

    // R6: write aimed at the live bank (0) is dropped and flagged
    cfgCoef(0, 3, 0, 5000);
    chk(cfgErr === 1'b1, "R6", longint'(cfgErr), 1);
    rampTurn(2500, -100, "R6");
    cfgCoef(1, 3, 0, 7000);
    chk(cfgErr === 1'b1, "R6", longint'(cfgErr), 1);

    // R4: tap count 0 becomes 1, 20 becomes 16
    cfgLen(1, 0);
    selectNext(1);
    rampTurn(3000, 200, "R4");
    cfgCoef(0, 6, 10, 20000);
    cfgLen(0, 20);
    selectNext(0);
    rampTurn(-3000, 150, "R4");
    rampTurn(1000, 0, "R4");

    // R3: a lone impulse on slice 5 stays in slice 5
    impulseTurn(5, 1000, "R3");
    impulseTurn(5, 0, "R3");
    impulseTurn(5, 0, "R3");

    // R10: mid-run reset clears histories and configuration
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    modelReset();
    selectNext(0);
    chk(outValid === 1'b0 && cfgErr === 1'b0, "R10", longint'(cfgErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    rampTurn(1500, 33, "R10");
    loadBank(1, 1'b1);
    selectNext(1);
    rampTurn(1500, 33, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule